// File: doc/BRIEF.md
# Multi-Channel State Initialization Sequencer

This block clears the per-channel algorithm state of a four-channel transcoder. Two sources start a full clear: an external active-low reset pin, which must be seen low on two consecutive master-clock edges to count, and a power-on reset, which acts at once. Either one holds the block in reset. On release the block runs a fixed-length sweep. During the sweep it writes default values into every word of the shared state memory, driving a write-enable, a channel index and a word index. It ignores the frame strobe until the sweep is over. Normal processing restarts on the first falling edge of the strobe after the sweep ends.

Once running, frames rotate through channels 0 to 3, and every falling edge of the strobe opens the frame of the next channel. If the init request is high at that edge, the block stores that channel's configuration word and rewrites only that channel's state words. It holds back the frame-start pulse until the rewrite is done. A frame that carries an init must last at least 45 master clocks, and a shorter one is flagged when the next strobe falls. The state values themselves and the data path live outside this block.

Top module: `chan_init_seq`

## Requirements
- R1: A single-cycle low on `ext_rst_n` has no effect. When `ext_rst_n` is sampled low on two consecutive edges, the block enters reset after the second of them: `busy`=1, `running`=0 and `cfg_all`=0. It stays in reset while the pin is low.
- R2: `por_n` low for one edge has the same effect as R1. After it is released, the same sweep follows.
- R3: The first edge that samples the reset released starts the sweep. `busy` stays 1 for 726 edges counted from that edge, and drops after the 726th.
- R4: During the sweep, `mem_we` is 1 for the first 128 sweep cycles, one state word per cycle in ascending order. The word index is `mem_word` (low 5 bits, 0..31) and the channel is `mem_ch` (0..3). `mem_we` is 0 for the rest of the sweep.
- R5: Strobe edges in reset or during the sweep, including those within 6 clocks of release, produce no `frame_go` and leave `running` at 0.
- R6: The first falling edge of `fs` after the sweep sets `running`. It produces a one-cycle `frame_go` with `frame_ch`=0 after the edge at which the fall is sampled.
- R7: Each later falling edge opens the frame of the next channel in the order 0,1,2,3,0. A frame without init gives `frame_go` one cycle after the edge, with `frame_ch` set to that channel.
- R8: If `init_req` is 1 at a frame's falling edge, `cfg_in` is stored in that channel's slot of `cfg_all`, bits [4n+3:4n]. In `cfg_in`, bit 3 is the PCM law, bit 2 the enable and bits 1:0 the rate. A frame without init leaves `cfg_all` unchanged.
- R9: An init frame raises `busy` and writes that channel's 32 words, 0..31, on 32 consecutive cycles. `frame_go` for that channel follows in the next cycle, with `busy` low.
- R10: `frame_err` pulses at the falling edge that ends an init frame shorter than 45 clocks. An init frame of 45 or more clocks, and any non-init frame, leaves it at 0.
- R11: A falling edge during an init rewrite advances the channel. Its `init_req` is ignored, it produces no `frame_go`, and the rewrite runs to completion.
- R12: A qualified reset on the same edge as an init strobe wins. No configuration is stored and the block enters reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst_n | input | 1 | External global reset pin, active low, needs two low edges |
| fs | input | 1 | Frame strobe; falling edge opens a frame |
| init_req | input | 1 | Single-channel init request, sampled at the strobe fall |
| cfg_in | input | 4 | Channel configuration {law, enable, rate[1:0]} |
| busy | output | 1 | Reset hold, sweep or single-channel rewrite in progress |
| running | output | 1 | Normal frame processing has resumed |
| frame_go | output | 1 | One-cycle frame-processing start |
| frame_ch | output | 2 | Channel of the frame started by `frame_go` |
| frame_err | output | 1 | Init frame was shorter than the minimum |
| mem_we | output | 1 | State-memory write enable |
| mem_ch | output | 2 | Channel index of the state-memory write |
| mem_word | output | 5 | Word index within the channel |
| cfg_all | output | 16 | Stored configurations, channel n in bits [4n+3:4n] |

## Verification
Two functions can meet on one edge: a qualified global reset and a strobe fall that carries an init request. The bench holds the reset pin low for one cycle, then drops the strobe with the init request high while the pin is still low. Both therefore arrive on the edge that qualifies the reset. The result is judged at the ports: the configuration must stay cleared, no frame start may appear, and `busy` must rise. A second overlap, a strobe fall in the middle of an init rewrite, is judged by a missing frame start, an error pulse and the channel numbering of the frames that follow.

// File: rtl/chinit_pkg.sv
// Shared types for the channel-state initialization sequencer.
// Assumes: configuration words are four bits wide.
package chinit_pkg;
    localparam int CFG_W = 4;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_SWEEP,
        ST_WAIT,
        ST_RUN,
        ST_INIT
    } seq_st_e;

    typedef struct packed {
        logic       law;
        logic       en;
        logic [1:0] rate;
    } chan_cfg_t;
endpackage

// File: rtl/chinit_rst_qual.sv
// Qualifies the external reset pin: it is accepted only when it is sampled
// low on two consecutive edges, so a one-cycle glitch does nothing.
// Assumes: the pin is already synchronous to clk.
module chinit_rst_qual (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    output logic glob_rst
);
    logic prev_n;

    // keep the previous pin sample
    always_ff @(posedge clk) begin
        if (!por_n) prev_n <= 1'b1;
        else        prev_n <= ext_rst_n;
    end

    assign glob_rst = !ext_rst_n && !prev_n;
endmodule

// File: rtl/chinit_frame_timer.sv
// Detects strobe falls and measures init-frame length. It flags an init
// frame that ends before MIN_FRAME clocks.
// Assumes: fs is synchronous; accept is low whenever strobes must be ignored.
module chinit_frame_timer #(
    parameter int MIN_FRAME = 45
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic fs,
    input  logic accept,
    input  logic init_start,
    output logic fall,
    output logic frame_err
);
    localparam int LEN_W = $clog2(MIN_FRAME + 1);

    logic             fs_q;
    logic             armed;
    logic [LEN_W-1:0] len;
    logic             fall_ok;

    // previous strobe sample for edge detection
    always_ff @(posedge clk) begin
        if (!por_n) fs_q <= 1'b0;
        else        fs_q <= fs;
    end

    assign fall    = fs_q && !fs;
    assign fall_ok = fall && accept;

    // frame length counter, init marker and error pulse
    always_ff @(posedge clk) begin
        if (!por_n || clr) begin
            armed     <= 1'b0;
            len       <= '0;
            frame_err <= 1'b0;
        end else if (fall_ok) begin
            frame_err <= armed && (len < LEN_W'(MIN_FRAME - 1));
            armed     <= init_start;
            len       <= '0;
        end else begin
            frame_err <= 1'b0;
            if (len != LEN_W'(MIN_FRAME)) len <= len + 1'b1;
        end
    end

    a_r10_err_needs_init: assert property (@(posedge clk) disable iff (!por_n)
        frame_err |-> $past(armed));
endmodule

// File: rtl/chinit_cfg_bank.sv
// Holds one configuration word per channel. A global clear wins over a write.
// Assumes: at most one write per cycle.
module chinit_cfg_bank #(
    parameter int NUM_CH = 4,
    parameter int CFG_W  = 4
) (
    input  logic                      clk,
    input  logic                      por_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    input  logic [CFG_W-1:0]          wr_cfg,
    output logic [NUM_CH*CFG_W-1:0]   cfg_all
);
    localparam int CH_W = $clog2(NUM_CH);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [CFG_W-1:0] slot;

        // store this channel's word on a matching write
        always_ff @(posedge clk) begin
            if (!por_n || clr)                     slot <= '0;
            else if (wr_en && wr_ch == CH_W'(g))   slot <= wr_cfg;
        end

        assign cfg_all[g*CFG_W +: CFG_W] = slot;
    end

    a_r1_cfg_cleared: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (cfg_all == '0));
endmodule

// File: rtl/chan_init_seq.sv
// Top of the channel-state initialization sequencer. It runs the full sweep
// after a reset, rotates frames through the channels, rewrites one channel on
// request, and gates frame starts until the state memory is ready.
// Assumes: NUM_CH and CH_WORDS are powers of two, and
// NUM_CH*CH_WORDS <= SWEEP_CYC.
module chan_init_seq
    import chinit_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int CH_WORDS  = 32,
    parameter int SWEEP_CYC = 726,
    parameter int MIN_FRAME = 45
) (
    input  logic                          clk,
    input  logic                          por_n,
    input  logic                          ext_rst_n,
    input  logic                          fs,
    input  logic                          init_req,
    input  logic [3:0]                    cfg_in,
    output logic                          busy,
    output logic                          running,
    output logic                          frame_go,
    output logic [$clog2(NUM_CH)-1:0]     frame_ch,
    output logic                          frame_err,
    output logic                          mem_we,
    output logic [$clog2(NUM_CH)-1:0]     mem_ch,
    output logic [$clog2(CH_WORDS)-1:0]   mem_word,
    output logic [NUM_CH*4-1:0]           cfg_all
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int WORD_W = $clog2(CH_WORDS);
    localparam int TOTAL  = NUM_CH * CH_WORDS;
    localparam int CNT_W  = $clog2(SWEEP_CYC);

    seq_st_e            st;
    logic [CNT_W-1:0]   cnt;
    logic [WORD_W-1:0]  wcnt;
    logic [CH_W-1:0]    cur_ch;
    logic [CH_W-1:0]    init_ch;
    logic [CH_W-1:0]    nxt_ch;
    logic               glob_rst;
    logic               fall;
    logic               accept;
    logic               init_start;
    logic               sweep_we;
    chan_cfg_t          cfg_word;

    chinit_rst_qual u_rst (
        .clk       (clk),
        .por_n     (por_n),
        .ext_rst_n (ext_rst_n),
        .glob_rst  (glob_rst)
    );

    // strobes count only once the state memory is ready
    assign accept     = !glob_rst && (st == ST_WAIT || st == ST_RUN || st == ST_INIT);
    assign init_start = fall && init_req && !glob_rst && (st == ST_WAIT || st == ST_RUN);
    assign nxt_ch     = (st == ST_WAIT) ? '0 : cur_ch + 1'b1;
    assign cfg_word   = chan_cfg_t'(cfg_in);

    chinit_frame_timer #(.MIN_FRAME(MIN_FRAME)) u_timer (
        .clk        (clk),
        .por_n      (por_n),
        .clr        (glob_rst || st == ST_HOLD || st == ST_SWEEP),
        .fs         (fs),
        .accept     (accept),
        .init_start (init_start),
        .fall       (fall),
        .frame_err  (frame_err)
    );

    chinit_cfg_bank #(.NUM_CH(NUM_CH), .CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .por_n   (por_n),
        .clr     (glob_rst),
        .wr_en   (init_start),
        .wr_ch   (nxt_ch),
        .wr_cfg  (cfg_word),
        .cfg_all (cfg_all)
    );

    // sequencer state, sweep and rewrite counters, frame rotation
    always_ff @(posedge clk) begin
        if (!por_n) begin
            st       <= ST_HOLD;
            cnt      <= '0;
            wcnt     <= '0;
            cur_ch   <= '0;
            init_ch  <= '0;
            frame_go <= 1'b0;
            frame_ch <= '0;
        end else begin
            frame_go <= 1'b0;
            if (glob_rst) begin
                st <= ST_HOLD;
            end else begin
                case (st)
                    ST_HOLD: begin
                        if (ext_rst_n) begin
                            st  <= ST_SWEEP;
                            cnt <= '0;
                        end
                    end
                    ST_SWEEP: begin
                        if (cnt == CNT_W'(SWEEP_CYC - 1)) st <= ST_WAIT;
                        else                              cnt <= cnt + 1'b1;
                    end
                    ST_WAIT, ST_RUN: begin
                        if (fall) begin
                            cur_ch <= nxt_ch;
                            if (init_req) begin
                                st      <= ST_INIT;
                                wcnt    <= '0;
                                init_ch <= nxt_ch;
                            end else begin
                                st       <= ST_RUN;
                                frame_go <= 1'b1;
                                frame_ch <= nxt_ch;
                            end
                        end
                    end
                    ST_INIT: begin
                        if (fall) cur_ch <= cur_ch + 1'b1;
                        if (wcnt == WORD_W'(CH_WORDS - 1)) begin
                            st       <= ST_RUN;
                            frame_go <= 1'b1;
                            frame_ch <= init_ch;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                    default: st <= ST_HOLD;
                endcase
            end
        end
    end

    // state-memory write port
    assign sweep_we = (st == ST_SWEEP) && (cnt < CNT_W'(TOTAL));
    always_comb begin
        mem_we   = sweep_we || (st == ST_INIT);
        mem_ch   = '0;
        mem_word = '0;
        if (st == ST_INIT) begin
            mem_ch   = init_ch;
            mem_word = wcnt;
        end else if (sweep_we) begin
            mem_ch   = cnt[WORD_W +: CH_W];
            mem_word = cnt[WORD_W-1:0];
        end
    end

    assign busy    = (st == ST_HOLD) || (st == ST_SWEEP) || (st == ST_INIT);
    assign running = (st == ST_RUN) || (st == ST_INIT);

    a_r4_write_while_busy: assert property (@(posedge clk) disable iff (!por_n)
        mem_we |-> busy);
    a_r3_sweep_length: assert property (@(posedge clk) disable iff (!por_n)
        (st == ST_WAIT && $past(st) == ST_SWEEP) |-> $past(cnt) == CNT_W'(SWEEP_CYC - 1));
    a_r6_go_when_ready: assert property (@(posedge clk) disable iff (!por_n)
        frame_go |-> (running && !busy));
    a_r5_no_go_in_sweep: assert property (@(posedge clk) disable iff (!por_n)
        (st == ST_SWEEP) |=> !frame_go);
    a_r9_rewrite_one_channel: assert property (@(posedge clk) disable iff (!por_n)
        (st == ST_INIT && $past(st) == ST_INIT) |-> $stable(mem_ch));
    a_r12_reset_wins: assert property (@(posedge clk) disable iff (!por_n)
        glob_rst |=> (busy && !running));
endmodule

// File: tb/sim_chan_init_seq.sv
// Directed bench for chan_init_seq: one task per scenario.
module sim_chan_init_seq;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        fs = 1'b0;
    logic        init_req = 1'b0;
    logic [3:0]  cfg_in = 4'h0;
    logic        busy, running, frame_go, frame_err, mem_we;
    logic [1:0]  frame_ch, mem_ch;
    logic [4:0]  mem_word;
    logic [15:0] cfg_all;

    int          n_chk = 0;
    int          n_fail = 0;
    int          next_ch = 0;
    logic [15:0] exp_cfg = 16'h0;

    chan_init_seq u0 (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .fs(fs),
        .init_req(init_req), .cfg_in(cfg_in), .busy(busy), .running(running),
        .frame_go(frame_go), .frame_ch(frame_ch), .frame_err(frame_err),
        .mem_we(mem_we), .mem_ch(mem_ch), .mem_word(mem_word), .cfg_all(cfg_all)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_fall(input logic ir, input logic [3:0] c);
        fs = 1'b1;
        tick();
        fs = 1'b0;
        init_req = ir;
        cfg_in = c;
        tick();
        init_req = 1'b0;
        cfg_in = 4'h0;
    endtask

    // caller has just released the reset at this negedge
    task automatic sweep_check(input string tag);
        int bad_we = 0, bad_busy = 0, bad_go = 0;
        for (int j = 0; j < 726; j++) begin
            fs = (j < 700) ? ((j % 7) < 3) : 1'b0;
            tick();
            if (!busy) bad_busy++;
            if (frame_go || running) bad_go++;
            if (j < 128) begin
                if (!mem_we || mem_ch != 2'(j / 32) || mem_word != 5'(j % 32)) bad_we++;
            end else if (mem_we) begin
                bad_we++;
            end
        end
        check(bad_busy == 0, {tag, " R3 busy through sweep"}, bad_busy, 0);
        check(bad_we == 0, {tag, " R4 sweep write order"}, bad_we, 0);
        check(bad_go == 0, {tag, " R5 strobes ignored in sweep"}, bad_go, 0);
        tick();
        check(!busy && !running, {tag, " R3 sweep ends after 726"}, {busy, running}, 0);
        next_ch = 0;
        exp_cfg = 16'h0;
    endtask

    task automatic plain_frame(input string req);
        do_fall(1'b0, 4'hA);
        check(frame_go && frame_ch == 2'(next_ch), req, {frame_go, frame_ch}, {1'b1, 2'(next_ch)});
        next_ch = (next_ch + 1) % 4;
    endtask

    // init frame: store config, 32 writes, then frame start
    task automatic init_frame(input logic [3:0] c);
        int ch, bad;
        ch = next_ch;
        bad = 0;
        do_fall(1'b1, c);
        exp_cfg[ch*4 +: 4] = c;
        check(cfg_all == exp_cfg, "R8 config stored", cfg_all, exp_cfg);
        check(busy && !frame_go, "R9 busy during rewrite", {busy, frame_go}, 2'b10);
        for (int j = 0; j < 32; j++) begin
            if (!mem_we || mem_ch != 2'(ch) || mem_word != 5'(j)) bad++;
            tick();
        end
        check(bad == 0, "R9 rewrite words", bad, 0);
        check(!mem_we && frame_go && frame_ch == 2'(ch) && !busy, "R9 frame start after rewrite",
              {mem_we, frame_go, frame_ch, busy}, {2'b01, 2'(ch), 1'b0});
        next_ch = (next_ch + 1) % 4;
    endtask

    task automatic t_reset_state();
        repeat (3) tick();
        check(busy && !running, "R2 reset state busy", {busy, running}, 2'b10);
        check(!mem_we && !frame_go && !frame_err, "R2 reset state quiet", {mem_we, frame_go, frame_err}, 0);
        check(cfg_all == 16'h0, "R2 reset state config", cfg_all, 0);
    endtask

    task automatic t_power_up();
        por_n = 1'b1;
        sweep_check("power-up");
    endtask

    task automatic t_first_frame();
        repeat (5) tick();
        do_fall(1'b0, 4'h0);
        check(running && frame_go && frame_ch == 2'd0, "R6 first frame resumes on channel 0",
              {running, frame_go, frame_ch}, 4'b1100);
        next_ch = 1;
    endtask

    task automatic t_rotation();
        for (int k = 0; k < 5; k++) begin
            repeat (3) tick();
            plain_frame("R7 rotation");
        end
        check(cfg_all == exp_cfg, "R8 no change without init", cfg_all, exp_cfg);
    endtask

    task automatic t_init_len();
        repeat (2) tick();
        init_frame(4'b1011);
        repeat (10) tick();
        do_fall(1'b0, 4'h0);
        check(frame_err == 1'b1, "R10 init frame of 44 flagged", frame_err, 1);
        next_ch = (next_ch + 1) % 4;
        init_frame(4'b0110);
        repeat (11) tick();
        do_fall(1'b0, 4'h0);
        check(frame_err == 1'b0, "R10 init frame of 45 accepted", frame_err, 0);
        next_ch = (next_ch + 1) % 4;
        repeat (5) tick();
        do_fall(1'b0, 4'h0);
        check(frame_err == 1'b0, "R10 short plain frame not flagged", frame_err, 0);
        next_ch = (next_ch + 1) % 4;
    endtask

    task automatic t_overlap();
        int a, n;
        repeat (2) tick();
        a = next_ch;
        do_fall(1'b1, 4'b0011);
        exp_cfg[a*4 +: 4] = 4'b0011;
        repeat (8) tick();
        do_fall(1'b1, 4'b1111);
        check(!frame_go && frame_err && mem_we && mem_ch == 2'(a), "R11 fall inside rewrite",
              {frame_go, frame_err, mem_we, mem_ch}, {3'b011, 2'(a)});
        check(cfg_all == exp_cfg, "R11 init inside rewrite ignored", cfg_all, exp_cfg);
        n = 0;
        while (!frame_go && n < 40) begin
            tick();
            n++;
        end
        check(frame_go && frame_ch == 2'(a) && n == 22, "R11 rewrite completes", n, 22);
        next_ch = (a + 2) % 4;
        repeat (15) tick();
        do_fall(1'b0, 4'h0);
        check(frame_go && frame_ch == 2'(next_ch) && !frame_err, "R11 rotation continues",
              frame_ch, next_ch);
        next_ch = (next_ch + 1) % 4;
    endtask

    task automatic t_short_reset();
        ext_rst_n = 1'b0;
        tick();
        ext_rst_n = 1'b1;
        tick();
        tick();
        check(running && !busy && cfg_all == exp_cfg, "R1 one-cycle reset ignored", cfg_all, exp_cfg);
        plain_frame("R1 frames continue after glitch");
        ext_rst_n = 1'b0;
        tick();
        tick();
        check(busy && !running && cfg_all == 16'h0, "R1 two-cycle reset clears",
              {busy, running, cfg_all}, 18'h20000);
        repeat (3) tick();
        check(busy && !running, "R1 held in reset", {busy, running}, 2'b10);
        ext_rst_n = 1'b1;
        sweep_check("pin reset");
    endtask

    task automatic t_reset_vs_init();
        repeat (3) tick();
        plain_frame("R6 frame after pin reset");
        init_frame(4'b1001);
        repeat (12) tick();
        ext_rst_n = 1'b0;
        fs = 1'b1;
        tick();
        fs = 1'b0;
        init_req = 1'b1;
        cfg_in = 4'hF;
        tick();
        init_req = 1'b0;
        cfg_in = 4'h0;
        check(busy && !running && !frame_go && !mem_we, "R12 reset beats init",
              {busy, running, frame_go, mem_we}, 4'b1000);
        check(cfg_all == 16'h0, "R12 no config stored", cfg_all, 0);
        repeat (2) tick();
        ext_rst_n = 1'b1;
        sweep_check("reset-vs-init");
    endtask

    task automatic t_por();
        repeat (3) tick();
        plain_frame("R6 frame before power-on reset");
        init_frame(4'b0101);
        repeat (12) tick();
        por_n = 1'b0;
        tick();
        check(busy && !running && cfg_all == 16'h0, "R2 power-on reset clears",
              {busy, running, cfg_all}, 18'h20000);
        por_n = 1'b1;
        sweep_check("R2 power-on");
        repeat (4) tick();
        plain_frame("R2 resumes on channel 0");
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_power_up();
        t_first_frame();
        t_rotation();
        t_init_len();
        t_overlap();
        t_short_reset();
        t_reset_vs_init();
        t_por();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule